// File: doc/BRIEF.md
# Oversampling Converter Conversion-Ready Timer

This block paces the output side of an oversampling converter's digital back end. It counts modulator ticks, and when a full output period has elapsed it loads a new word into a result holding register. In the same clock edge it pulls an active-low ready strobe low. The modulator and the filter arithmetic are not part of the block. The result word is modelled as a running count of completed conversions.

The output period is a fixed oversampling base multiplied by a decimation ratio. A three-bit code selects the ratio, and none of the ratios is a power of two. An optional divide-by-two halves the modulator tick rate, which doubles every period. A hold input stops the timing and parks the block idle. When hold is low, conversions follow each other without a gap.

The ready strobe returns high when the host signals that it has finished reading the word. If no read arrives, the strobe returns high a fixed number of ticks before the next word is loaded, so the host never samples a word that is being replaced. Reset parks the block in a known idle state. Any change to the rate settings restarts the period count from zero.

Top module: `drt_top`

## Requirements
- R1: The ratio code is {rng_sel_i, fsel_i[1], fsel_i[0]}, with rng_sel_i as the MSB. Codes 0 to 7 select ratios 391, 313, 78, 39, 384, 320, 77 and 38. One output period is ratio × OSR_BASE modulator ticks, and OSR_BASE is 128 by default.
- R2: When div_en_i is 0, every clock is a modulator tick. When div_en_i is 1, a tick occurs on every second clock, so the interval between successive falling edges of rdy_n_o doubles.
- R3: rdy_n_o falls on the same clock edge that loads a new word. Each load increments result_o by one, wrapping at 2^RES_W. rdy_n_o never falls at any other time.
- R4: A one-cycle pulse on rd_done_i drives rdy_n_o high on the next edge. A read has no effect on result_o. A load on the same edge takes priority over the read.
- R5: If no read occurs, rdy_n_o returns high BLANK ticks before the next load. With division off, the strobe therefore stays low for (period − BLANK) clocks.
- R6: While hold_i is 1, the tick count is held at zero, rdy_n_o is 1, no word is loaded and result_o keeps its value. After hold_i returns to 0, conversions repeat back to back.
- R7: While rst_n is 0, rdy_n_o is 1 and result_o is 0, both forced without waiting for a clock edge. No conversion completes during reset.
- R8: A change on rng_sel_i, fsel_i or div_en_i restarts the count. With division off, the next load comes exactly one full new period of clocks after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hold_i | input | 1 | 1 holds the block idle; 0 lets conversions run freely |
| rng_sel_i | input | 1 | Clock-range select, MSB of the ratio code |
| fsel_i | input | 2 | Filter select, low two bits of the ratio code |
| div_en_i | input | 1 | 1 halves the modulator tick rate |
| rd_done_i | input | 1 | One-cycle pulse marking a complete read of the result word |
| rdy_n_o | output | 1 | Active-low data-ready strobe |
| result_o | output | RES_W | Result holding register (conversion count) |

## Verification
The assertions assume that hold_i, rd_done_i and the rate-select inputs are synchronous to clk and change only between edges. They also assume that every period is longer than BLANK + 1 ticks. The stimulus drives every input on the falling clock edge. The bench uses an OSR_BASE of 4 and a BLANK of 8, so the shortest period is 152 ticks, well above the blanking window. Rate settings are changed either under hold or, for the restart case, mid-period while conversions run, and reads are issued only while the strobe is low.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef struct packed {
    logic       rng;
    logic [1:0] fsel;
    logic       div;
  } rate_cfg_t;

  // Decimation ratio for the 3-bit code {range, filter select}.
  function automatic int unsigned dec_ratio(input logic [2:0] code);
    int unsigned r;
    case (code)
      3'd0: r = 391;
      3'd1: r = 313;
      3'd2: r = 78;
      3'd3: r = 39;
      3'd4: r = 384;
      3'd5: r = 320;
      3'd6: r = 77;
      default: r = 38;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/drt_tick_gen.sv
module drt_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic div_en_i,
  output logic tick_o
);
  logic phase_q, phase_d;

  always_comb begin
    if (restart_i || !div_en_i) phase_d = 1'b0;
    else                        phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign tick_o = !div_en_i || phase_q;
endmodule

// File: rtl/drt_period_cnt.sv
module drt_period_cnt #(
  parameter int unsigned CW    = 16,
  parameter int unsigned BLANK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  output logic          load_o,
  output logic          blank_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end, at_blank, cnt_en;

  assign at_end   = (cnt_q == period_i - CW'(1));
  assign at_blank = (cnt_q == period_i - CW'(BLANK + 1));
  assign cnt_en   = restart_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign load_o  = !restart_i && tick_i && at_end;
  assign blank_o = !restart_i && tick_i && at_blank;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/drt_ready_ctrl.sv
module drt_ready_ctrl #(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             blank_i,
  input  logic             rd_done_i,
  output logic             rdy_n_o,
  output logic [RES_W-1:0] result_o
);
  logic             rdy_n_q, rdy_n_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    rdy_n_d = rdy_n_q;
    if (hold_i)                    rdy_n_d = 1'b1;
    else if (load_i)               rdy_n_d = 1'b0;
    else if (rd_done_i || blank_i) rdy_n_d = 1'b1;
  end

  always_comb begin
    res_d = res_q + RES_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n_q <= 1'b1;
    else        rdy_n_q <= rdy_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (load_i) res_q <= res_d;
  end

  assign rdy_n_o  = rdy_n_q;
  assign result_o = res_q;
endmodule

// File: rtl/drt_top.sv
module drt_top #(
  parameter int unsigned OSR_BASE    = 128,
  parameter int unsigned BLANK       = 8,
  parameter int unsigned RES_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             rng_sel_i,
  input  logic [1:0]       fsel_i,
  input  logic             div_en_i,
  input  logic             rd_done_i,
  output logic             rdy_n_o,
  output logic [RES_W-1:0] result_o
);
  import drt_pkg::*;

  localparam int unsigned MAX_PER = 391 * OSR_BASE;
  localparam int unsigned CW      = $clog2(MAX_PER + 1);

  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // Rate configuration tracking and restart detection.
  rate_cfg_t     cfg_d, cfg_q;
  logic          cfg_chg, restart_w, tick_w, load_w, blank_w;
  logic [CW-1:0] per_w, cnt_w;

  always_comb begin
    cfg_d.rng  = rng_sel_i;
    cfg_d.fsel = fsel_i;
    cfg_d.div  = div_en_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  assign cfg_chg   = (cfg_d != cfg_q);
  assign restart_w = hold_i || cfg_chg;
  assign per_w     = CW'(dec_ratio({cfg_q.rng, cfg_q.fsel}) * OSR_BASE);

  drt_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (restart_w),
    .div_en_i  (cfg_q.div),
    .tick_o    (tick_w)
  );

  drt_period_cnt #(.CW(CW), .BLANK(BLANK)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (restart_w),
    .tick_i    (tick_w),
    .period_i  (per_w),
    .load_o    (load_w),
    .blank_o   (blank_w),
    .cnt_o     (cnt_w)
  );

  drt_ready_ctrl #(.RES_W(RES_W)) u_rdy (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hold_i    (hold_i),
    .load_i    (load_w),
    .blank_i   (blank_w),
    .rd_done_i (rd_done_i),
    .rdy_n_o   (rdy_n_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/drt_top_chk.sv
module drt_top_chk #(
  parameter int unsigned CW    = 16,
  parameter int unsigned RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_i,
  input logic             rd_done_i,
  input logic             rdy_n_o,
  input logic [RES_W-1:0] result_o,
  input logic             load_w,
  input logic [CW-1:0]    cnt_w,
  input logic [CW-1:0]    per_w
);
  // R6: hold parks the strobe inactive
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> rdy_n_o);

  // R6: hold keeps the tick count at zero
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_w == '0));

  // R4: a read without a competing load releases the strobe
  a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_i && !load_w && !hold_i) |=> rdy_n_o);

  // R3: a load drops the strobe and advances the result by one
  a_r3_load_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (!rdy_n_o && (result_o == $past(result_o) + RES_W'(1))));

  // R3: the strobe only falls after a load
  a_r3_fall_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n_o) |-> $past(load_w));

  // R1: the tick count stays inside the selected period
  a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w < per_w);
endmodule

bind drt_top drt_top_chk #(.CW(CW), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_i    (hold_i),
  .rd_done_i (rd_done_i),
  .rdy_n_o   (rdy_n_o),
  .result_o  (result_o),
  .load_w    (load_w),
  .cnt_w     (cnt_w),
  .per_w     (per_w)
);

// File: tb/drt_top_test.sv
`timescale 1ns/1ps
module drt_top_test;
  localparam int BASE  = 4;
  localparam int BLANK = 8;
  localparam int RW    = 16;
  localparam int WD    = 190000;

  logic          clk = 1'b0;
  logic          rst_n, hold_i, rng_sel_i, div_en_i, rd_done_i;
  logic [1:0]    fsel_i;
  logic          rdy_n_o;
  logic [RW-1:0] result_o;

  always #2.5 clk = ~clk;

  drt_top #(.OSR_BASE(BASE), .BLANK(BLANK), .RES_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .rng_sel_i(rng_sel_i),
    .fsel_i(fsel_i), .div_en_i(div_en_i), .rd_done_i(rd_done_i),
    .rdy_n_o(rdy_n_o), .result_o(result_o)
  );

  int cyc = 0;
  int total = 0;
  int bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    int r;
    case (code)
      0: r = 391; 1: r = 313; 2: r = 78;  3: r = 39;
      4: r = 384; 5: r = 320; 6: r = 77;  default: r = 38;
    endcase
    return r;
  endfunction

  // Scoreboard: expected falling-edge intervals and their tags
  int    exp_q[$];
  string tag_q[$];
  bit    mon_en = 1'b0;
  bit    have_ref = 1'b0;
  logic  rdy_prev = 1'b1;
  int    last_fall = 0;

  always @(negedge clk) begin
    if (mon_en && rdy_prev === 1'b1 && rdy_n_o === 1'b0) begin
      if (have_ref && exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cyc - last_fall, e);
      end
      have_ref  = 1'b1;
      last_fall = cyc;
    end
    if (hold_i) have_ref = 1'b0;
    rdy_prev = rdy_n_o;
  end

  task automatic set_code(input int code, input bit dv);
    rng_sel_i = code[2];
    fsel_i    = code[1:0];
    div_en_i  = dv;
  endtask

  // Driver: configure under hold, release, queue two expected intervals
  task automatic run_cfg(input int code, input bit dv);
    int p;
    @(negedge clk);
    hold_i = 1'b1;
    set_code(code, dv);
    repeat (3) @(negedge clk);
    p = ratio_of(code) * BASE * (dv ? 2 : 1);
    for (int k = 0; k < 2; k++) begin
      exp_q.push_back(p);
      tag_q.push_back(dv ? "R2 interval (div on)" : "R1 interval (div off)");
    end
    hold_i = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic wait_fall();
    logic p;
    p = rdy_n_o;
    forever begin
      @(negedge clk);
      if (p === 1'b1 && rdy_n_o === 1'b0) break;
      p = rdy_n_o;
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): actual=%0d cycles expected=completion", WD);
    finish_run();
  end

  initial begin
    int res0, n, t0;
    bit ok;
    rst_n = 1'b0; hold_i = 1'b1; rd_done_i = 1'b0;
    set_code(0, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 reset rdy_n", rdy_n_o, 1);
    check("R7 reset result", result_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: every code, division off and on
    mon_en = 1'b1;
    for (int dv = 0; dv < 2; dv++)
      for (int c = 0; c < 8; c++)
        run_cfg(c, dv[0]);
    mon_en = 1'b0;

    // R6: hold keeps the block idle
    hold_i = 1'b1;
    set_code(3, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 hold rdy_n", rdy_n_o, 1);
    res0 = result_o;
    ok = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (rdy_n_o !== 1'b1 || result_o != res0[RW-1:0]) ok = 1'b0;
    end
    check("R6 idle while held", ok, 1);
    hold_i = 1'b0;

    // R3: fall with a new word
    wait_fall();
    check("R3 result after first load", result_o, res0 + 1);

    // R5: unread strobe releases BLANK ticks early
    n = 0;
    while (rdy_n_o === 1'b0) begin
      @(negedge clk);
      n++;
    end
    check("R5 low width", n, 39 * BASE - BLANK);
    wait_fall();
    check("R3 result after second load", result_o, res0 + 2);

    // R4: read releases the strobe, result untouched
    rd_done_i = 1'b1;
    @(negedge clk);
    rd_done_i = 1'b0;
    check("R4 rdy_n after read", rdy_n_o, 1);
    check("R4 result unchanged by read", result_o, res0 + 2);

    // R8: mid-period rate change restarts the count
    wait_fall();
    repeat (50) @(negedge clk);
    set_code(0, 1'b0);
    @(negedge clk);
    t0 = cyc;
    wait_fall();
    check("R8 restart interval", cyc - t0, 391 * BASE);

    // R7: reset mid-run
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 rdy_n forced in reset", rdy_n_o, 1);
    check("R7 result cleared in reset", result_o, 0);
    ok = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rdy_n_o !== 1'b1 || result_o != '0) ok = 1'b0;
    end
    check("R7 no conversion in reset", ok, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule